// File: doc/BRIEF.md
# Operand Effective-Address Unit for a 1 MB Space

This unit turns an operand descriptor into the effective address a CPU's memory stage will use, in a 20-bit (1 MB) address space. It takes the addressing mode, the base register value, the program counter, the 16-bit index word that follows the opcode, and the 4-bit upper-index nibble that an extended instruction carries in its prefix word. It supports register-relative (indexed), PC-relative (symbolic), absolute, register-indirect and post-incrementing indirect operands. The unit never performs the memory access itself.

Two families of instructions share the unit. Older 16-bit-index instructions have a split rule. If the base sits in the lowest 64 kB, the result is kept inside that window. Otherwise the signed 16-bit index is applied to the full 20-bit base. Extended instructions build a signed 20-bit index from the nibble and the index word, and reach any address. For the post-incrementing mode, the unit also produces the new base register value. Illegal combinations raise an error flag, and the base register is then returned unchanged.

A request is presented with `req_vld_i`. All results are registered and appear one clock later, together with `vld_o`. They keep their values until the next request.

Top module: `oag_top`

## Requirements
- R1: Indexed mode (code 0), legacy instruction (`ext_instr_i`=0), base bits 19:16 all zero: `ea_o` = {4'h0, (base[15:0] + index) mod 2^16}.
- R2: Indexed mode, legacy instruction, base at or above 0x10000: `ea_o` = (base + index sign-extended from bit 15) mod 2^20.
- R3: Indexed mode, extended instruction: `ea_o` = (base + the signed 20-bit value {ext_i, idx_i}) mod 2^20. For example, index 0xFFFD0 subtracts 0x30.
- R4: Symbolic mode (code 1) follows the R1–R3 rules with `pc_i` in place of `base_i`.
- R5: Absolute mode (code 2) ignores both bases. A legacy instruction yields {4'h0, idx_i}, and an extended one yields {ext_i, idx_i}.
- R6: Indirect mode (code 3) on a source operand yields `ea_o` = base, with `wb_en_o`=0.
- R7: Auto-increment mode (code 4) on a source operand yields `ea_o` = base and `wb_en_o`=1. It also yields `base_wb_o` = (base + 1, 2 or 4) mod 2^20 for size codes 0 (byte), 1 (word) and 2 (20-bit address).
- R8: Each of the following raises `err_o`=1, with `wb_en_o`=0, `ea_o`=0 and `base_wb_o`=`base_i`: indirect or auto-increment with `src_op_i`=0, mode codes 5–7, or auto-increment with size code 3.
- R9: Results appear on the clock edge after `req_vld_i` is sampled high, with `vld_o`=1 for that one cycle. Without a request, `vld_o`=0 and all other outputs hold.
- R10: While `rst_ni` is low, every output is 0.
- R11: When there is no error and the mode is not auto-increment, `base_wb_o` equals `base_i` and `wb_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| src_op_i | input | 1 | 1 = source operand, 0 = destination |
| size_i | input | 2 | Operand size code for auto-increment |
| ext_instr_i | input | 1 | 1 = extended (20-bit index) instruction |
| base_i | input | 20 | Base register value |
| pc_i | input | 20 | Program counter value |
| idx_i | input | 16 | Index / absolute word |
| ext_i | input | 4 | Upper index nibble from the prefix word |
| vld_o | output | 1 | Result valid, one cycle after a request |
| ea_o | output | 20 | Effective address |
| base_wb_o | output | 20 | Value to write back to the base register |
| wb_en_o | output | 1 | Base register write-back enable |
| err_o | output | 1 | Illegal request flag |

## Verification
A wrong internal result always surfaces at the next clock edge, because the unit holds no state beyond its one output register. The reference model in the bench is therefore compared with the outputs in every cycle.

The cases that separate a correct design from a faulty one are these:
- the 64 kB window boundary in both directions;
- 16-bit wrap that must stay confined, compared with 20-bit wrap that must not;
- negative extended indices;
- an increment that crosses 0xFFFFF.

A corrupted error decode would appear as a missing write-back or a changed base in that same cycle.

// File: rtl/oag_pkg.sv
package oag_pkg;
   localparam logic [2:0] MODE_INDEXED  = 3'd0;
   localparam logic [2:0] MODE_SYMBOLIC = 3'd1;
   localparam logic [2:0] MODE_ABSOLUTE = 3'd2;
   localparam logic [2:0] MODE_INDIRECT = 3'd3;
   localparam logic [2:0] MODE_AUTOINC  = 3'd4;

   localparam logic [1:0] SIZE_BYTE = 2'd0;
   localparam logic [1:0] SIZE_WORD = 2'd1;
   localparam logic [1:0] SIZE_ADDR = 2'd2;

   typedef struct packed {
      logic rel;      // index added to a base
      logic use_pc;   // base is the program counter
      logic absolute; // base is zero
      logic indirect; // address is the base itself
      logic autoinc;  // base is incremented afterwards
      logic err;      // illegal request
   } oag_dec_t;
endpackage

// File: rtl/oag_mode_dec.sv
module oag_mode_dec
   import oag_pkg::*;
(
   input  logic [2:0] mode_i,
   input  logic       src_op_i,
   input  logic [1:0] size_i,
   output oag_dec_t   dec_o
);
   always_comb begin
      dec_o = '0;
      unique case (mode_i)
         MODE_INDEXED:  dec_o.rel = 1'b1;
         MODE_SYMBOLIC: begin
            dec_o.rel    = 1'b1;
            dec_o.use_pc = 1'b1;
         end
         MODE_ABSOLUTE: begin
            dec_o.rel      = 1'b1;
            dec_o.absolute = 1'b1;
         end
         MODE_INDIRECT: begin
            dec_o.indirect = src_op_i;
            dec_o.err      = !src_op_i;
         end
         MODE_AUTOINC: begin
            dec_o.autoinc = src_op_i && (size_i != 2'd3);
            dec_o.err     = !src_op_i || (size_i == 2'd3);
         end
         default: dec_o.err = 1'b1;
      endcase
   end
endmodule

// File: rtl/oag_index_add.sv
module oag_index_add #(
   parameter int ADDR_W = 20,
   parameter int IDX_W  = 16
) (
   input  logic [ADDR_W-1:0]       base_i,
   input  logic [IDX_W-1:0]        idx_i,
   input  logic [ADDR_W-IDX_W-1:0] ext_i,
   input  logic                    ext_instr_i,
   output logic [ADDR_W-1:0]       sum_o
);
   localparam int EXT_W = ADDR_W - IDX_W;

   generate
      if (EXT_W < 1) begin : g_bad_width
         $error("oag_index_add: ADDR_W must exceed IDX_W");
      end
   endgenerate

   logic [ADDR_W-1:0] idx_sext;
   logic [ADDR_W-1:0] idx_full;
   logic [ADDR_W-1:0] sum_ext;
   logic [ADDR_W-1:0] sum_leg;
   logic [IDX_W-1:0]  sum_low;
   logic              base_in_low;

   assign idx_sext    = {{EXT_W{idx_i[IDX_W-1]}}, idx_i};
   assign idx_full    = {ext_i, idx_i};
   assign sum_ext     = base_i + idx_full;
   assign sum_leg     = base_i + idx_sext;
   assign sum_low     = base_i[IDX_W-1:0] + idx_i;
   assign base_in_low = (base_i[ADDR_W-1:IDX_W] == '0);

   always_comb begin
      if (ext_instr_i)      sum_o = sum_ext;
      else if (base_in_low) sum_o = {{EXT_W{1'b0}}, sum_low};
      else                  sum_o = sum_leg;
   end
endmodule

// File: rtl/oag_incr.sv
module oag_incr
   import oag_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [1:0]        size_i,
   output logic [ADDR_W-1:0] next_o
);
   logic [ADDR_W-1:0] step;

   always_comb begin
      unique case (size_i)
         SIZE_BYTE: step = ADDR_W'(1);
         SIZE_WORD: step = ADDR_W'(2);
         SIZE_ADDR: step = ADDR_W'(4);
         default:   step = '0;
      endcase
   end

   assign next_o = base_i + step;
endmodule

// File: rtl/oag_top.sv
module oag_top
   import oag_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int IDX_W  = 16
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    req_vld_i,
   input  logic [2:0]              mode_i,
   input  logic                    src_op_i,
   input  logic [1:0]              size_i,
   input  logic                    ext_instr_i,
   input  logic [ADDR_W-1:0]       base_i,
   input  logic [ADDR_W-1:0]       pc_i,
   input  logic [IDX_W-1:0]        idx_i,
   input  logic [ADDR_W-IDX_W-1:0] ext_i,
   output logic                    vld_o,
   output logic [ADDR_W-1:0]       ea_o,
   output logic [ADDR_W-1:0]       base_wb_o,
   output logic                    wb_en_o,
   output logic                    err_o
);
   oag_dec_t          dec;
   logic [ADDR_W-1:0] add_base;
   logic [ADDR_W-1:0] add_sum;
   logic [ADDR_W-1:0] inc_val;
   logic [ADDR_W-1:0] ea_nxt;
   logic [ADDR_W-1:0] wb_nxt;

   oag_mode_dec u_dec (
      .mode_i   (mode_i),
      .src_op_i (src_op_i),
      .size_i   (size_i),
      .dec_o    (dec)
   );

   always_comb begin
      if (dec.absolute)    add_base = '0;
      else if (dec.use_pc) add_base = pc_i;
      else                 add_base = base_i;
   end

   oag_index_add #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_add (
      .base_i      (add_base),
      .idx_i       (idx_i),
      .ext_i       (ext_i),
      .ext_instr_i (ext_instr_i),
      .sum_o       (add_sum)
   );

   oag_incr #(.ADDR_W(ADDR_W)) u_inc (
      .base_i (base_i),
      .size_i (size_i),
      .next_o (inc_val)
   );

   always_comb begin
      if (dec.err)                         ea_nxt = '0;
      else if (dec.indirect | dec.autoinc) ea_nxt = base_i;
      else                                 ea_nxt = add_sum;
      wb_nxt = dec.autoinc ? inc_val : base_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_o     <= 1'b0;
         ea_o      <= '0;
         base_wb_o <= '0;
         wb_en_o   <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         vld_o <= req_vld_i;
         if (req_vld_i) begin
            ea_o      <= ea_nxt;
            base_wb_o <= wb_nxt;
            wb_en_o   <= dec.autoinc;
            err_o     <= dec.err;
         end
      end
   end
endmodule

// File: rtl/oag_checker.sv
module oag_checker
   import oag_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int IDX_W  = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              req_vld_i,
   input logic [2:0]        mode_i,
   input logic              ext_instr_i,
   input logic [ADDR_W-1:0] base_i,
   input logic              vld_o,
   input logic [ADDR_W-1:0] ea_o,
   input logic [ADDR_W-1:0] base_wb_o,
   input logic              wb_en_o,
   input logic              err_o
);
   // R9: a result only follows a request
   a_r9_vld_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> $past(req_vld_i));

   // R9: outputs hold while idle
   a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_o |-> ($stable(ea_o) && $stable(base_wb_o) && $stable(err_o)));

   // R8: an error leaves the base untouched
   a_r8_err_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && err_o) |-> (!wb_en_o && ea_o == '0 && base_wb_o == $past(base_i)));

   // R7: write-back only for auto-increment
   a_r7_wb_autoinc_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && wb_en_o) |-> ($past(mode_i) == MODE_AUTOINC && !err_o));

   // R6: indirect address equals the base
   a_r6_indirect_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && !err_o && $past(mode_i) == MODE_INDIRECT) |-> (ea_o == $past(base_i)));

   // R1: legacy indexed from the low window stays in the low window
   a_r1_low_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && $past(mode_i) == MODE_INDEXED && !$past(ext_instr_i)
       && $past(base_i[ADDR_W-1:IDX_W]) == '0) |-> (ea_o[ADDR_W-1:IDX_W] == '0));
endmodule

bind oag_top oag_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_oag_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_vld_i   (req_vld_i),
   .mode_i      (mode_i),
   .ext_instr_i (ext_instr_i),
   .base_i      (base_i),
   .vld_o       (vld_o),
   .ea_o        (ea_o),
   .base_wb_o   (base_wb_o),
   .wb_en_o     (wb_en_o),
   .err_o       (err_o)
);

// File: tb/tb_oag_top.sv
`timescale 1ns/1ps
module tb_oag_top;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        req_vld_i = 1'b0;
   logic [2:0]  mode_i = '0;
   logic        src_op_i = 1'b0;
   logic [1:0]  size_i = '0;
   logic        ext_instr_i = 1'b0;
   logic [19:0] base_i = '0;
   logic [19:0] pc_i = '0;
   logic [15:0] idx_i = '0;
   logic [3:0]  ext_i = '0;
   logic        vld_o, wb_en_o, err_o;
   logic [19:0] ea_o, base_wb_o;

   always #5 clk = ~clk;

   oag_top dut (
      .clk_i(clk), .rst_ni(rst_ni), .req_vld_i(req_vld_i), .mode_i(mode_i),
      .src_op_i(src_op_i), .size_i(size_i), .ext_instr_i(ext_instr_i),
      .base_i(base_i), .pc_i(pc_i), .idx_i(idx_i), .ext_i(ext_i),
      .vld_o(vld_o), .ea_o(ea_o), .base_wb_o(base_wb_o),
      .wb_en_o(wb_en_o), .err_o(err_o)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   // expected output state
   logic        x_vld = 0, x_wb_en = 0, x_err = 0;
   logic [19:0] x_ea = 0, x_wb = 0;
   string       x_tag = "R10";

   function automatic longint rel_addr(longint base, longint idx, longint ext, bit xi);
      longint full, sidx;
      if (xi) begin
         full = ext * 65536 + idx;
         sidx = (full >= 'h80000) ? full - 'h100000 : full;
         return (base + sidx + 'h100000) % 'h100000;
      end
      if (base < 'h10000) return (base + idx) % 'h10000;
      sidx = (idx >= 'h8000) ? idx - 'h10000 : idx;
      return (base + sidx + 'h100000) % 'h100000;
   endfunction

   task automatic model();
      longint b, step;
      string  t;
      b = base_i;
      x_vld = 1; x_wb_en = 0; x_err = 0; x_wb = base_i; t = "R11";
      if (mode_i > 4 || (mode_i >= 3 && !src_op_i) || (mode_i == 4 && size_i == 3)) begin
         x_err = 1; x_ea = 0; x_tag = "R8"; return;
      end
      case (mode_i)
         0: begin
            x_ea = 20'(rel_addr(b, idx_i, ext_i, ext_instr_i));
            t = ext_instr_i ? "R3" : (b < 'h10000 ? "R1" : "R2");
         end
         1: begin x_ea = 20'(rel_addr(pc_i, idx_i, ext_i, ext_instr_i)); t = "R4"; end
         2: begin x_ea = ext_instr_i ? {ext_i, idx_i} : {4'h0, idx_i}; t = "R5"; end
         3: begin x_ea = base_i; t = "R6"; end
         default: begin
            step = (size_i == 0) ? 1 : (size_i == 1) ? 2 : 4;
            x_ea = base_i; x_wb = 20'((b + step) % 'h100000); x_wb_en = 1; t = "R7";
         end
      endcase
      x_tag = t;
   endtask

   task automatic check_now();
      n_checks++;
      if (vld_o !== x_vld || ea_o !== x_ea || base_wb_o !== x_wb ||
          wb_en_o !== x_wb_en || err_o !== x_err) begin
         n_fail++;
         $display("FAIL %s: got vld=%0b ea=%05h wb=%05h wben=%0b err=%0b exp vld=%0b ea=%05h wb=%05h wben=%0b err=%0b",
                  x_tag, vld_o, ea_o, base_wb_o, wb_en_o, err_o,
                  x_vld, x_ea, x_wb, x_wb_en, x_err);
      end
   endtask

   // one cycle: check at negedge, then drive and predict the next edge
   task automatic step_req(bit rq, logic [2:0] m, bit s, logic [1:0] sz, bit xi,
                           logic [19:0] b, logic [19:0] p, logic [15:0] ix, logic [3:0] e);
      @(negedge clk);
      check_now();
      req_vld_i = rq; mode_i = m; src_op_i = s; size_i = sz; ext_instr_i = xi;
      base_i = b; pc_i = p; idx_i = ix; ext_i = e;
      if (rq) model();
      else begin x_vld = 0; x_tag = "R9"; end
   endtask

   initial begin
      // R10: reset state
      repeat (3) begin @(negedge clk); check_now(); end
      rst_ni = 1'b1;
      // R1: signed index from the low window, 0x1234 - 0x30
      step_req(1, 0, 1, 1, 0, 20'h01234, 0, 16'hFFD0, 0);
      // R1: 16-bit wrap stays confined below 64 kB
      step_req(1, 0, 1, 1, 0, 20'h0FFF0, 0, 16'h0020, 0);
      // R2: base above 64 kB, negative index crosses down
      step_req(1, 0, 0, 1, 0, 20'h10010, 0, 16'hFFD0, 0);
      // R3: extended negative index wraps the 1 MB space
      step_req(1, 0, 0, 1, 1, 20'h00010, 0, 16'hFFD0, 4'hF);
      step_req(1, 0, 0, 1, 1, 20'h45678, 0, 16'h0002, 4'h1);
      // R4: symbolic, low and high PC
      step_req(1, 1, 1, 1, 0, 20'h77777, 20'h00200, 16'h0002, 0);
      step_req(1, 1, 1, 1, 0, 20'h00000, 20'h10200, 16'h8000, 0);
      // R5: absolute ignores bases
      step_req(1, 2, 0, 1, 0, 20'hABCDE, 20'h12345, 16'h1234, 4'h3);
      step_req(1, 2, 0, 1, 1, 20'hABCDE, 20'h12345, 16'h1234, 4'h3);
      // R6: indirect
      step_req(1, 3, 1, 1, 0, 20'h9ABCD, 0, 16'h1111, 0);
      // R7: auto-increment sizes and wrap
      step_req(1, 4, 1, 0, 0, 20'h00100, 0, 0, 0);
      step_req(1, 4, 1, 1, 0, 20'h00100, 0, 0, 0);
      step_req(1, 4, 1, 2, 0, 20'hFFFFE, 0, 0, 0);
      // R8: illegal requests
      step_req(1, 4, 0, 1, 0, 20'h12345, 0, 0, 0);
      step_req(1, 3, 0, 1, 0, 20'h12345, 0, 0, 0);
      step_req(1, 6, 1, 1, 0, 20'h54321, 0, 0, 0);
      step_req(1, 4, 1, 3, 0, 20'h22222, 0, 0, 0);
      // R9: idle cycles hold
      step_req(0, 0, 0, 0, 0, 20'hFFFFF, 20'hFFFFF, 16'hFFFF, 4'hF);
      step_req(0, 2, 1, 2, 1, 20'h00000, 20'h00000, 16'h0000, 4'h0);
      // random mix, all requirements
      for (int i = 0; i < 400; i++) begin
         logic [19:0] rb;
         rb = ($urandom % 2) ? 20'($urandom) : {4'h0, 16'($urandom)};
         step_req(($urandom % 4) != 0, 3'($urandom), 1'($urandom), 2'($urandom),
                  1'($urandom), rb, 20'($urandom), 16'($urandom), 4'($urandom));
      end
      @(negedge clk); check_now();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule